// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 14-bit virtual address into a 16-bit physical address by way of a four-entry segment table. The two most significant address bits pick a table entry. The twelve bits below them are an offset into that segment. Each entry holds its own relocation base, its largest legal offset, a valid flag and separate read and write permission flags. Because of this, one process can have several independently placed and protected regions. Two entries, or the tables of two processes, may also point at the same physical region so that it is shared.

Privileged software loads the table one entry per clock through a configuration port. Translation is combinational. In the same cycle as a request, the block gives either the relocated address with a valid strobe or a fault indication. The fault and its cause are also captured in a status register at the end of every request cycle, so a trap handler can read them afterwards.

Top module: `seg_xlate`

## Requirements
- R1: Virtual address bits [13:12] select the table entry and bits [11:0] are the offset within that segment.
- R2: For a request that does not fault, `pa_out` equals the selected entry's base plus the zero-extended offset, modulo 2^16, and `pa_vld` is 1 in the same cycle as `req_vld`.
- R3: An offset greater than the entry's limit faults with cause code 2. An offset equal to the limit is legal.
- R4: A request to an entry whose valid flag is 0 faults with cause code 1. This check takes priority over the limit and permission checks.
- R5: A read (`req_write`=0) needs the entry's read flag and a write (`req_write`=1) needs its write flag. Otherwise the request faults with cause code 3, which has the lowest priority.
- R6: During a faulting request, `flt_now` is 1, `pa_vld` is 0 and `pa_out` is 0. `flt_now` and `pa_vld` are 0 whenever `req_vld` is 0.
- R7: At each rising edge with `req_vld`=1, `flt_q` and `cause_q` capture that request's fault flag and cause (0 when there is no fault). In cycles without a request they hold their value.
- R8: A rising edge with `cfg_we`=1 writes all fields of entry `cfg_idx`. The other entries keep their contents. The new contents are used from the next cycle on, so a request in the same cycle as the write sees the old entry.
- R9: After reset every entry is invalid, and `flt_q`=0 and `cause_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 2 | Entry index to write |
| cfg_base | input | 16 | Physical base of the segment |
| cfg_limit | input | 12 | Largest legal offset |
| cfg_valid | input | 1 | Entry valid flag |
| cfg_rd_ok | input | 1 | Reads permitted |
| cfg_wr_ok | input | 1 | Writes permitted |
| req_vld | input | 1 | Access request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_va | input | 14 | Virtual address |
| pa_out | output | 16 | Translated physical address |
| pa_vld | output | 1 | Translation valid, no fault |
| flt_now | output | 1 | Current request faults |
| flt_q | output | 1 | Registered fault flag |
| cause_q | output | 2 | Registered cause: 0 none, 1 invalid, 2 limit, 3 permission |

## Verification
`pa_out`, `pa_vld` and `flt_now` depend combinationally on the request and the current table. The bench drives the request just after a falling edge and samples these outputs a short delay later, before the next rising edge. `flt_q` and `cause_q` are due one rising edge after the request, so the bench samples them just after that edge and only then changes the inputs. A table write takes effect at the edge that ends its cycle, so the bench reads the new contents only from the following cycle, and it separately checks that a request in the write's own cycle still sees the old entry.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEG_W  = 2;
  localparam int OFF_W  = 12;
  localparam int VA_W   = SEG_W + OFF_W;
  localparam int PA_W   = 16;
  localparam int N_SEG  = 1 << SEG_W;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_SEG   = 2'd1,
    CAUSE_LIMIT = 2'd2,
    CAUSE_PERM  = 2'd3
  } cause_e;

  typedef struct packed {
    logic             valid;
    logic             rd_ok;
    logic             wr_ok;
    logic [PA_W-1:0]  base;
    logic [OFF_W-1:0] limit;
  } seg_ent_t;

  function automatic logic [SEG_W-1:0] va_seg(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] va_off(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] reloc(input logic [PA_W-1:0] base,
                                            input logic [OFF_W-1:0] off);
    logic [PA_W-1:0] ext;
    ext = PA_W'(off);
    return base + ext;
  endfunction

  function automatic cause_e judge(input seg_ent_t e,
                                   input logic [OFF_W-1:0] off,
                                   input logic is_wr);
    if (!e.valid)                  return CAUSE_SEG;
    if (off > e.limit)             return CAUSE_LIMIT;
    if (is_wr ? !e.wr_ok : !e.rd_ok) return CAUSE_PERM;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  seg_ent_t         wr_ent,
  input  logic [SEG_W-1:0] rd_idx,
  output seg_ent_t         rd_ent
);

  seg_ent_t ents [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ents[g] <= '0;
      else if (hit) ents[g] <= wr_ent;
    end
  end

  assign rd_ent = ents[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  logic             req_vld,
  input  logic             req_write,
  input  logic [OFF_W-1:0] off,
  input  seg_ent_t         ent,
  output logic             fault,
  output cause_e           cause,
  output logic             ok,
  output logic [PA_W-1:0]  pa
);

  cause_e verdict;

  always_comb begin
    verdict = judge(ent, off, req_write);
    cause   = req_vld ? verdict : CAUSE_NONE;
    fault   = req_vld && (verdict != CAUSE_NONE);
    ok      = req_vld && (verdict == CAUSE_NONE);
    pa      = ok ? reloc(ent.base, off) : '0;
  end

endmodule

// File: rtl/seg_status.sv
module seg_status
  import seg_xlate_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   capture,
  input  logic   fault_in,
  input  cause_e cause_in,
  output logic   fault_q,
  output cause_e cause_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (capture) begin
      fault_q <= fault_in;
      cause_q <= cause_in;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFF_W-1:0] cfg_limit,
  input  logic             cfg_valid,
  input  logic             cfg_rd_ok,
  input  logic             cfg_wr_ok,
  input  logic             req_vld,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_va,
  output logic [PA_W-1:0]  pa_out,
  output logic             pa_vld,
  output logic             flt_now,
  output logic             flt_q,
  output logic [1:0]       cause_q
);

  seg_ent_t         wr_ent;
  seg_ent_t         sel_ent;
  logic [SEG_W-1:0] seg_idx;
  logic [OFF_W-1:0] seg_off;
  cause_e           cause_now;
  cause_e           cause_reg;
  logic             xlate_ok;

  assign wr_ent  = '{valid: cfg_valid, rd_ok: cfg_rd_ok, wr_ok: cfg_wr_ok,
                     base: cfg_base, limit: cfg_limit};
  assign seg_idx = va_seg(req_va);
  assign seg_off = va_off(req_va);

  seg_table u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_idx),
    .wr_ent (wr_ent),
    .rd_idx (seg_idx),
    .rd_ent (sel_ent)
  );

  seg_check u_check (
    .req_vld   (req_vld),
    .req_write (req_write),
    .off       (seg_off),
    .ent       (sel_ent),
    .fault     (flt_now),
    .cause     (cause_now),
    .ok        (xlate_ok),
    .pa        (pa_out)
  );

  seg_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (req_vld),
    .fault_in (flt_now),
    .cause_in (cause_now),
    .fault_q  (flt_q),
    .cause_q  (cause_reg)
  );

  assign pa_vld  = xlate_ok;
  assign cause_q = cause_reg;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_vld,
  input logic       pa_vld,
  input logic       flt_now,
  input logic [1:0] cause_now,
  input logic       flt_q,
  input logic [1:0] cause_q
);

  AST_FAULT_BLOCKS_PA: assert property (@(posedge clk) disable iff (!rst_n)
    flt_now |-> !pa_vld); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> (!pa_vld && !flt_now)); // R6

  AST_REQ_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> (pa_vld != flt_now)); // R2

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_now |-> (cause_now != 2'd0)); // R3

  AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (flt_q == $past(flt_now) && cause_q == $past(cause_now))); // R7

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(flt_q) && $stable(cause_q))); // R7

endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .pa_vld    (pa_vld),
  .flt_now   (flt_now),
  .cause_now (cause_now),
  .flt_q     (flt_q),
  .cause_q   (cause_q)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0;
  logic [11:0] cfg_limit = '0;
  logic        cfg_valid = 1'b0, cfg_rd_ok = 1'b0, cfg_wr_ok = 1'b0;
  logic        req_vld = 1'b0, req_write = 1'b0;
  logic [13:0] req_va = '0;
  logic [15:0] pa_out;
  logic        pa_vld, flt_now, flt_q;
  logic [1:0]  cause_q;

  int checks = 0;
  int errors = 0;

  logic        m_valid [4];
  logic        m_rd    [4];
  logic        m_wr    [4];
  logic [15:0] m_base  [4];
  logic [11:0] m_limit [4];
  logic        last_flt;
  logic [1:0]  last_cause;

  always #5 clk = ~clk;

  seg_xlate uut (.*);

  // Reference cause: 1 invalid, 2 limit exceeded, 3 permission, 0 none
  function automatic logic [1:0] ref_cause(input logic [13:0] va, input logic wr);
    int s;
    s = int'(va / 4096);
    if (!m_valid[s]) return 2'd1;
    if (int'(va % 4096) > int'(m_limit[s])) return 2'd2;
    if (wr && !m_wr[s]) return 2'd3;
    if (!wr && !m_rd[s]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [15:0] ref_pa(input logic [13:0] va);
    int s;
    s = int'(va / 4096);
    return 16'((int'(m_base[s]) + int'(va % 4096)) % 65536);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [15:0] b, input logic [11:0] l,
                      input logic v, input logic r, input logic w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_base = b; cfg_limit = l;
    cfg_valid = v; cfg_rd_ok = r; cfg_wr_ok = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_valid[idx] = v; m_rd[idx] = r; m_wr[idx] = w;
    m_base[idx] = b; m_limit[idx] = l;
  endtask

  // Drive one access, check combinational outputs then registered status
  task automatic access(input logic [13:0] va, input logic wr, input string req);
    logic [1:0]  ec;
    logic [15:0] ep;
    ec = ref_cause(va, wr);
    ep = (ec == 2'd0) ? ref_pa(va) : 16'h0;
    @(negedge clk);
    req_vld = 1'b1; req_write = wr; req_va = va;
    #2;
    check(pa_vld == (ec == 2'd0), {req, " pa_vld"}, int'(pa_vld), int'(ec == 2'd0));
    check(flt_now == (ec != 2'd0), {req, " flt_now"}, int'(flt_now), int'(ec != 2'd0));
    check(pa_out == ep, {req, " pa_out"}, int'(pa_out), int'(ep));
    @(posedge clk); #1;
    req_vld = 1'b0;
    check(cause_q == ec, {req, " R7 cause_q"}, int'(cause_q), int'(ec));
    check(flt_q == (ec != 2'd0), {req, " R7 flt_q"}, int'(flt_q), int'(ec != 2'd0));
    last_flt = (ec != 2'd0); last_cause = ec;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5E6A11));
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_base[i] = 0; m_limit[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(flt_q == 1'b0 && cause_q == 2'd0, "R9 status after reset", int'(cause_q), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R9: every entry invalid after reset -> cause 1
    for (int s = 0; s < 4; s++) access(14'(s * 4096 + 5), 1'b0, "R9 R4 empty table");

    // R1/R2: distinct bases, segment picked by top bits
    load(0, 16'h1000, 12'hFFF, 1, 1, 1);
    load(1, 16'h4000, 12'h0FF, 1, 1, 0);
    load(2, 16'hF800, 12'hFFF, 1, 0, 1);
    load(3, 16'h8000, 12'h010, 0, 1, 1);
    access(14'h0123, 1'b0, "R1 R2 seg0 read");
    access(14'h1045, 1'b0, "R1 R2 seg1 read");
    // R3: limit boundary
    access(14'h10FF, 1'b0, "R3 offset equal limit");
    access(14'h1100, 1'b0, "R3 offset over limit");
    // R5: permission per direction
    access(14'h1010, 1'b1, "R5 write to read-only");
    access(14'h2010, 1'b0, "R5 read to write-only");
    access(14'h2010, 1'b1, "R5 write allowed");
    // R2: wrap modulo 2^16
    access(14'h2FFF, 1'b1, "R2 wrap");
    // R4: invalid wins over limit
    access(14'h3FFF, 1'b0, "R4 invalid priority");
    // R3 over R5: over limit and no write permission on seg1
    access(14'h1800, 1'b1, "R3 limit before permission");

    // R7: idle cycles hold status
    access(14'h1800, 1'b0, "R7 set fault");
    repeat (3) @(posedge clk);
    #1;
    check(flt_q == 1'b1 && cause_q == 2'd2, "R7 hold when idle", int'(cause_q), 2);

    // R8: write during a request sees old entry; other entries untouched
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd3; cfg_base = 16'h2222; cfg_limit = 12'hFFF;
    cfg_valid = 1; cfg_rd_ok = 1; cfg_wr_ok = 1;
    req_vld = 1'b1; req_write = 1'b0; req_va = 14'h3004;
    #2;
    check(flt_now == 1'b1 && pa_vld == 1'b0, "R8 same-cycle sees old", int'(flt_now), 1);
    @(posedge clk); #1;
    cfg_we = 1'b0; req_vld = 1'b0;
    m_valid[3] = 1; m_rd[3] = 1; m_wr[3] = 1; m_base[3] = 16'h2222; m_limit[3] = 12'hFFF;
    access(14'h3004, 1'b0, "R8 new entry used");
    access(14'h0004, 1'b0, "R8 other entry kept");
    // sharing: two segments with one base
    load(1, 16'h1000, 12'hFFF, 1, 1, 1);
    access(14'h1777, 1'b0, "R2 shared region seg1");
    access(14'h0777, 1'b0, "R2 shared region seg0");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 9) == 0)
        load(int'($urandom_range(0, 3)), 16'($urandom), 12'($urandom),
             logic'($urandom_range(0, 5) != 0), logic'($urandom_range(0, 3) != 0),
             logic'($urandom_range(0, 3) != 0));
      else begin
        int s;
        logic [11:0] off;
        s = int'($urandom_range(0, 3));
        case ($urandom_range(0, 3))
          0: off = m_limit[s];
          1: off = m_limit[s] + 12'd1;
          default: off = 12'($urandom);
        endcase
        access(14'(s * 4096) | 14'(off), logic'($urandom_range(0, 1)), "R2 R3 R5 random");
        if ($urandom_range(0, 4) == 0) begin
          @(posedge clk); #1;
          check(flt_q == last_flt && cause_q == last_cause, "R7 random idle hold",
                int'(cause_q), int'(last_cause));
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule